// File: doc/BRIEF.md
# Half-to-Double Float Conversion Unit

This block widens an IEEE binary16 value to IEEE binary64. The operand is the low halfword (bits 15:0) of a 64-bit source word, and the upper 48 bits of that word are not used. When `in_valid` is high, the unit converts the operand with combinational logic and registers the outcome on the next rising clock edge. The outcome is a 128-bit vector. Its low doubleword holds the binary64 value and its high doubleword is always zero. Alongside it the unit produces a write strobe, a signaling-NaN invalid flag, an exception-summary set request, a 5-bit result-class code with its own update strobe, and two rounding status bits that are always zero.

Every binary16 value has an exact binary64 form, so the unit has no rounding logic. Subnormal halves are normalised with a leading-one search. NaNs keep their sign and have their payload left-aligned in the fraction. A signaling NaN is made quiet before it is widened, and it raises the invalid flag. If the invalid-exception enable input is high when a signaling NaN arrives, the write and the class update are both withheld, so the previously written result and class stay visible.

Top module: `fp_h2d_top`

## Requirements
- R1: Only `src_dw[15:0]` affects the outputs. Two operands that differ only in bits 63:16 give identical outputs.
- R2: On every write, `result[127:64]` is all zeros.
- R3: A normal half with sign s, exponent e (1..30) and fraction m gives `result[63:0]` = {s, e+1008 (11 bits), m, 42 zero bits}.
- R4: A subnormal half (e=0, m≠0) is normalised. Let p be the bit position of m's leading one. The result has exponent p+999, and its fraction is the bits of m below that leading one, left-aligned in the 52-bit field.
- R5: A zero half gives the binary64 zero of the same sign. An infinity half (e=31, m=0) gives {s, 11'h7FF, 52'b0}.
- R6: A quiet NaN half (e=31, m[9]=1) gives {s, 11'h7FF, m, 42'b0}.
- R7: A signaling NaN half (e=31, m≠0, m[9]=0) gives {s, 11'h7FF, m with bit 9 set, 42'b0}. In the same cycle, `snan_flag` and `fx_set` are both 1. For every other input, both are 0.
- R8: If a signaling NaN arrives while `inv_en`=1, `wr_en` and `class_upd` stay 0, and `result` and `class_code` keep their previous values. With `inv_en`=1, any other input is written normally.
- R9: When a write happens, `class_code` is computed from the binary64 result using these codes: NaN 10001, -inf 01001, -normal 01000, -subnormal 11000, -zero 10010, +zero 00010, +subnormal 10100, +normal 00100, +inf 00101.
- R10: `fr_out` and `fi_out` are 0 at all times.
- R11: The outputs change on the first rising edge after `in_valid`=1. `wr_en`, `class_upd`, `snan_flag` and `fx_set` are one-cycle pulses, and they are 0 in any cycle that does not follow an accepted strobe. After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Conversion strobe |
| src_dw | input | 64 | Source doubleword; operand in bits 15:0 |
| inv_en | input | 1 | Invalid-exception enable |
| result | output | 128 | Registered result vector |
| wr_en | output | 1 | Result write pulse |
| snan_flag | output | 1 | Signaling-NaN invalid flag pulse |
| fx_set | output | 1 | Exception-summary set request pulse |
| class_code | output | 5 | Result-class code |
| class_upd | output | 1 | Class-code update pulse |
| fr_out | output | 1 | Fraction-rounded status, always 0 |
| fi_out | output | 1 | Fraction-inexact status, always 0 |

## Verification
The hardest case to bring about is the suppressed write. It can only be seen against an earlier, different value still held in the result and class registers. The stimulus therefore writes a known normal value first and then presents a signaling NaN with `inv_en` high. It then presents a quiet NaN with `inv_en` still high, to show that only signaling NaNs are blocked. A final pass covers all 65536 halfwords, with changing upper bits, against an independent arithmetic model, so that every subnormal shift distance and every NaN payload is reached.

// File: rtl/fp_h2d_pkg.sv
package fp_h2d_pkg;
    localparam int HALF_E  = 5;
    localparam int HALF_F  = 10;
    localparam int HALF_W  = 1 + HALF_E + HALF_F;
    localparam int DBL_E   = 11;
    localparam int DBL_F   = 52;
    localparam int DBL_W   = 1 + DBL_E + DBL_F;
    localparam int VEC_W   = 2 * DBL_W;
    localparam int HALF_BIAS = (1 << (HALF_E - 1)) - 1;
    localparam int DBL_BIAS  = (1 << (DBL_E - 1)) - 1;
    localparam int PAD_F   = DBL_F - HALF_F;
    localparam int CLS_W   = 5;

    localparam logic [CLS_W-1:0] CLS_NAN  = 5'b10001;
    localparam logic [CLS_W-1:0] CLS_NINF = 5'b01001;
    localparam logic [CLS_W-1:0] CLS_NNRM = 5'b01000;
    localparam logic [CLS_W-1:0] CLS_NSUB = 5'b11000;
    localparam logic [CLS_W-1:0] CLS_NZER = 5'b10010;
    localparam logic [CLS_W-1:0] CLS_PZER = 5'b00010;
    localparam logic [CLS_W-1:0] CLS_PSUB = 5'b10100;
    localparam logic [CLS_W-1:0] CLS_PNRM = 5'b00100;
    localparam logic [CLS_W-1:0] CLS_PINF = 5'b00101;

    typedef struct packed {
        logic [VEC_W-1:0] vec;
        logic             wr;
        logic             cupd;
        logic             snan;
        logic             fx;
        logic [CLS_W-1:0] cls;
    } h2d_state_t;

    function automatic logic [CLS_W-1:0] classify_dbl(input logic [DBL_W-1:0] v);
        logic             s;
        logic [DBL_E-1:0] e;
        logic [DBL_F-1:0] f;
        s = v[DBL_W-1];
        e = v[DBL_W-2 -: DBL_E];
        f = v[DBL_F-1:0];
        if (&e)
            return (f != '0) ? CLS_NAN : (s ? CLS_NINF : CLS_PINF);
        else if (e == '0)
            return (f == '0) ? (s ? CLS_NZER : CLS_PZER) : (s ? CLS_NSUB : CLS_PSUB);
        else
            return s ? CLS_NNRM : CLS_PNRM;
    endfunction
endpackage

// File: rtl/fp_h2d_lzc.sv
module fp_h2d_lzc #(
    parameter int W  = 10,
    localparam int IW = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0]  vec,
    output logic [IW-1:0] idx,
    output logic          found
);
    logic [W-1:0] top_hot;

    genvar gi;
    generate
        for (gi = 0; gi < W; gi++) begin : g_hot
            if (gi == W - 1) begin : g_msb
                assign top_hot[gi] = vec[gi];
            end else begin : g_low
                assign top_hot[gi] = vec[gi] & ~(|vec[W-1:gi+1]);
            end
        end
    endgenerate

    always_comb begin
        idx = '0;
        for (int i = 0; i < W; i++) begin
            if (top_hot[i]) idx = idx | IW'(i);
        end
    end

    assign found = |vec;

    always_comb begin
        assert ($onehot0(top_hot)) else $error("AST_ONE_LEADER");  // R4
    end
endmodule

// File: rtl/fp_h2d_widen.sv
module fp_h2d_widen
    import fp_h2d_pkg::*;
(
    input  logic [HALF_W-1:0] half,
    output logic [DBL_W-1:0]  dbl,
    output logic              is_snan
);
    localparam int IW = $clog2(HALF_F);

    logic              s;
    logic [HALF_E-1:0] e;
    logic [HALF_F-1:0] m;
    logic [IW-1:0]     lead;
    logic              any_m;
    logic [IW-1:0]     sh;
    logic [HALF_F:0]   norm_m;
    logic [DBL_E-1:0]  e_norm;
    logic [DBL_E-1:0]  e_sub;

    assign s = half[HALF_W-1];
    assign e = half[HALF_W-2 -: HALF_E];
    assign m = half[HALF_F-1:0];

    fp_h2d_lzc #(.W(HALF_F)) u_lzc (
        .vec   (m),
        .idx   (lead),
        .found (any_m)
    );

    assign sh     = IW'(HALF_F) - lead;
    assign norm_m = {1'b0, m} << sh;
    assign e_norm = DBL_E'(e) + DBL_E'(DBL_BIAS - HALF_BIAS);
    assign e_sub  = DBL_E'(lead) + DBL_E'(DBL_BIAS - HALF_BIAS - HALF_F + 1);

    always_comb begin
        is_snan = 1'b0;
        if (e == '0) begin
            if (!any_m) dbl = {s, {(DBL_W-1){1'b0}}};
            else        dbl = {s, e_sub, norm_m[HALF_F-1:0], {PAD_F{1'b0}}};
        end else if (&e) begin
            if (!any_m) begin
                dbl = {s, {DBL_E{1'b1}}, {DBL_F{1'b0}}};
            end else begin
                is_snan = ~m[HALF_F-1];
                dbl = {s, {DBL_E{1'b1}}, 1'b1, m[HALF_F-2:0], {PAD_F{1'b0}}};
            end
        end else begin
            dbl = {s, e_norm, m, {PAD_F{1'b0}}};
        end
    end

    always_comb begin
        if (e == '0 && any_m)
            assert (norm_m[HALF_F]) else $error("AST_SUB_NORMALISED");  // R4
    end
endmodule

// File: rtl/fp_h2d_top.sv
module fp_h2d_top
    import fp_h2d_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [DBL_W-1:0]   src_dw,
    input  logic               inv_en,
    output logic [VEC_W-1:0]   result,
    output logic               wr_en,
    output logic               snan_flag,
    output logic               fx_set,
    output logic [CLS_W-1:0]   class_code,
    output logic               class_upd,
    output logic               fr_out,
    output logic               fi_out
);
    h2d_state_t       st_d, st_q;
    logic [DBL_W-1:0] conv;
    logic             conv_snan;
    logic             unused_hi;

    assign unused_hi = ^src_dw[DBL_W-1:HALF_W];

    fp_h2d_widen u_widen (
        .half    (src_dw[HALF_W-1:0]),
        .dbl     (conv),
        .is_snan (conv_snan)
    );

    always_comb begin
        st_d      = st_q;
        st_d.wr   = 1'b0;
        st_d.cupd = 1'b0;
        st_d.snan = 1'b0;
        st_d.fx   = 1'b0;
        if (in_valid) begin
            st_d.snan = conv_snan;
            st_d.fx   = conv_snan;
            if (!(inv_en && conv_snan)) begin
                st_d.vec  = {{DBL_W{1'b0}}, conv};
                st_d.wr   = 1'b1;
                st_d.cupd = 1'b1;
                st_d.cls  = classify_dbl(conv);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign result     = st_q.vec;
    assign wr_en      = st_q.wr;
    assign snan_flag  = st_q.snan;
    assign fx_set     = st_q.fx;
    assign class_code = st_q.cls;
    assign class_upd  = st_q.cupd;
    assign fr_out     = 1'b0;
    assign fi_out     = 1'b0;

    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (result[VEC_W-1:DBL_W] == '0));  // R2
    AST_SNAN_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        snan_flag |-> $past(in_valid && (&src_dw[14:10]) && !src_dw[9] && (src_dw[8:0] != '0)));  // R7
    AST_SUPPRESS: assert property (@(posedge clk) disable iff (!rst_n)
        (snan_flag && $past(inv_en)) |-> (!wr_en && !class_upd && $stable(result) && $stable(class_code)));  // R8
    AST_NAN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (&result[62:52]) && (result[51:0] != '0)) |-> result[51]);  // R7
    AST_PULSE_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en || class_upd || fx_set) |-> $past(in_valid));  // R11
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |-> $stable(result));  // R11
endmodule

// File: tb/fp_h2d_top_tb.sv
module fp_h2d_top_tb;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [63:0]  src_dw = '0;
    logic         inv_en = 1'b0;
    logic [127:0] result;
    logic         wr_en, snan_flag, fx_set, class_upd, fr_out, fi_out;
    logic [4:0]   class_code;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fp_h2d_top u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src_dw(src_dw),
        .inv_en(inv_en), .result(result), .wr_en(wr_en), .snan_flag(snan_flag),
        .fx_set(fx_set), .class_code(class_code), .class_upd(class_upd),
        .fr_out(fr_out), .fi_out(fi_out)
    );

    function automatic logic [63:0] ref_dbl(input logic [15:0] h);
        logic s; logic [4:0] e; logic [9:0] m; int p; logic [9:0] f;
        s = h[15]; e = h[14:10]; m = h[9:0];
        if (e == 0 && m == 0) return {s, 63'd0};
        if (e == 31 && m == 0) return {s, 11'h7FF, 52'd0};
        if (e == 31) return {s, 11'h7FF, m | 10'h200, 42'd0};
        if (e != 0) return {s, 11'(int'(e) - 15 + 1023), m, 42'd0};
        p = 0;
        for (int k = 0; k < 10; k++) if (m[k]) p = k;
        f = 10'((int'(m) * (1 << (10 - p))) % 1024);
        return {s, 11'(p - 24 + 1023), f, 42'd0};
    endfunction

    function automatic logic [4:0] ref_cls(input logic [15:0] h);
        if (h[14:10] == 31) return (h[9:0] != 0) ? 5'b10001 : (h[15] ? 5'b01001 : 5'b00101);
        if (h[14:0] == 0) return h[15] ? 5'b10010 : 5'b00010;
        return h[15] ? 5'b01000 : 5'b00100;
    endfunction

    function automatic bit is_sn(input logic [15:0] h);
        return (h[14:10] == 31) && !h[9] && (h[8:0] != 0);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic apply(input logic [63:0] s, input logic ie);
        @(negedge clk);
        src_dw = s; inv_en = ie; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic check_written(input logic [15:0] h, input string req);
        logic [127:0] exp;
        exp = {64'd0, ref_dbl(h)};
        chk(result == exp, req, result, exp);
        chk(wr_en && class_upd && class_code == ref_cls(h), {req, " R9 class"},
            {wr_en, class_upd, class_code}, {2'b11, ref_cls(h)});
        chk(snan_flag == is_sn(h) && fx_set == is_sn(h), {req, " R7 flags"},
            {snan_flag, fx_set}, {is_sn(h), is_sn(h)});
    endtask

    task automatic t_reset();
        chk(result == '0 && !wr_en && !class_upd && !snan_flag && !fx_set && class_code == 0,
            "R11 reset", {result[7:0], wr_en, class_upd, snan_flag, fx_set, class_code}, '0);
        chk(!fr_out && !fi_out, "R10 reset", {fr_out, fi_out}, '0);
    endtask

    task automatic t_directed();
        apply(64'h3C00, 1'b0);
        chk(result == {64'd0, 64'h3FF0000000000000}, "R3 one", result, {64'd0, 64'h3FF0000000000000});
        check_written(16'h3C00, "R3");
        apply(64'hC000, 1'b0); check_written(16'hC000, "R3 neg");
        apply(64'h0001, 1'b0);
        chk(result[63:0] == 64'h3E70000000000000, "R4 min sub", result, {64'd0, 64'h3E70000000000000});
        apply(64'h83FF, 1'b0); check_written(16'h83FF, "R4 max sub");
        apply(64'h8000, 1'b0); check_written(16'h8000, "R5 neg zero");
        apply(64'hFC00, 1'b0); check_written(16'hFC00, "R5 neg inf");
        apply(64'h7E55, 1'b0); check_written(16'h7E55, "R6 qnan");
        apply(64'h7C01, 1'b0);
        chk(result[63:0] == 64'h7FF8040000000000, "R7 snan quiet", result, {64'd0, 64'h7FF8040000000000});
        chk(snan_flag && fx_set && wr_en, "R7 snan flags", {snan_flag, fx_set, wr_en}, 3'b111);
        chk(!fr_out && !fi_out, "R10 after snan", {fr_out, fi_out}, '0);
    endtask

    task automatic t_timing();
        apply(64'h4000, 1'b0);
        chk(wr_en, "R11 pulse present", wr_en, 1);
        @(negedge clk);
        chk(!wr_en && !class_upd && !snan_flag && !fx_set, "R11 pulse ends",
            {wr_en, class_upd, snan_flag, fx_set}, '0);
        chk(result[63:0] == ref_dbl(16'h4000), "R11 result held", result, {64'd0, ref_dbl(16'h4000)});
    endtask

    task automatic t_upper_ignored();
        logic [127:0] r0; logic [4:0] c0;
        apply(64'h0000_0000_0000_1234, 1'b0);
        r0 = result; c0 = class_code;
        apply(64'hDEAD_BEEF_CAFE_1234, 1'b0);
        chk(result == r0 && class_code == c0, "R1 upper bits ignored", result, r0);
        check_written(16'h1234, "R1");
    endtask

    task automatic t_suppress();
        apply(64'h3C00, 1'b0);
        apply(64'hFFFF_0000_0000_7D00, 1'b1);
        chk(!wr_en && !class_upd, "R8 no write", {wr_en, class_upd}, '0);
        chk(snan_flag && fx_set, "R8 flags still set", {snan_flag, fx_set}, 2'b11);
        chk(result == {64'd0, 64'h3FF0000000000000} && class_code == 5'b00100,
            "R8 previous kept", {result[63:0], class_code}, {64'h3FF0000000000000, 5'b00100});
        chk(!fr_out && !fi_out, "R10 suppressed", {fr_out, fi_out}, '0);
        apply(64'hFE01, 1'b1);
        check_written(16'hFE01, "R8 qnan with enable");
    endtask

    task automatic t_sweep();
        for (int i = 0; i <= 65536; i++) begin
            @(negedge clk);
            if (i > 0) begin
                logic [15:0] h;
                logic [127:0] exp;
                h = 16'(i - 1);
                exp = {64'd0, ref_dbl(h)};
                chk(result == exp && wr_en && class_code == ref_cls(h) &&
                    snan_flag == is_sn(h) && fx_set == is_sn(h) && !fr_out && !fi_out,
                    "R2 R3 R4 R5 R6 R7 R9 sweep", {result[63:0], class_code, snan_flag},
                    {exp[63:0], ref_cls(h), is_sn(h)});
            end
            if (i < 65536) begin
                src_dw = {16'(i * 7), 16'(~i), 16'(i ^ 16'hA5A5), 16'(i)};
                inv_en = 1'b0;
                in_valid = 1'b1;
            end else begin
                in_valid = 1'b0;
            end
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_directed();
        t_timing();
        t_upper_ignored();
        t_suppress();
        t_sweep();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog R11 actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule